// File: doc/BRIEF.md
# Parallel I/O Base-Address Decoder

This block sits behind a host I/O cycle engine and decides whether an I/O address belongs to one of the on-chip logical devices. It holds one 32-bit base address register per device and compares every register with the cycle address in the same cycle. A hit raises a claim flag and reports the index of the winning register. It also gives the address on the internal peripheral bus, formed from the device's frame number and the offset of the byte inside its block.

Each register packs a 16-bit host base, a valid flag, a device flag, a 6-bit frame number and an 8-bit mask. Mask bits at 1 leave the matching low address bits out of the comparison, so one base can cover a block of up to 256 byte registers. The registers are programmed a byte at a time through a small register port. Some fields are fixed and cannot be written. A sticky flag records any cycle that more than one valid register matched.

Top module: `io_bar_decoder`

## Requirements
- R1: After reset, BAR i reads back its reset default. With the default parameters these are: BAR0 002E_0C01h, BAR1 0060_0104h, BAR2 0062_0304h, BAR3 0066_0407h, BAR4 0092_0600h, BAR5 0000_0507h, BAR6 0000_0707h and BAR7 0000_0901h. The conflict flag and the claim output are 0.
- R2: A BAR with its valid bit (bit 15) at 0 never claims a cycle, even when its base equals the cycle address.
- R3: A valid BAR matches when the cycle address equals its base (bits 31:16) on every bit whose mask bit (bits 7:0, widened with zeros to 16 bits) is 0.
- R4: On a claim, the peripheral address is frame (bits 13:8) × 400h plus (cycle address bits 7:0 AND mask), and hit_idx gives the index of the matching BAR.
- R5: When several valid BARs match, the BAR with the lowest index wins. The conflict flag is set in the cycle after and stays set.
- R6: A write with data bit 0 at 1 to register-port address 4×NUM_BARS (the status byte, which reads as {7'b0, conflict}) clears the conflict flag. A write with bit 0 at 0 leaves the flag unchanged.
- R7: Register-port address 4×i+b selects byte b of BAR i. Bytes 3 and 2 (host base) are fully writable. In byte 1 only bit 7 (valid) is writable; the device bit and the frame bits ignore writes.
- R8: The mask byte (byte 0) is writable only in BARs whose MASK_RW bit is 1 (BARs 2 and 3 by default). In all other BARs the mask keeps its reset value.
- R9: The outputs are registered. claim is 1 in the cycle after a strobe with io_valid at 1 that matched. claim, hit_idx and pbus_addr are 0 after any cycle without a strobe or without a match.
- R10: Register-port addresses above the status byte read FFh, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | Host I/O cycle strobe |
| io_addr | input | 16 | Host I/O cycle address |
| reg_wr | input | 1 | Register-port byte write |
| reg_addr | input | REG_AW (6) | Register-port byte address |
| reg_wdata | input | 8 | Register-port write data |
| reg_rdata | output | 8 | Register-port read data (combinational) |
| claim | output | 1 | Cycle claimed (registered) |
| hit_idx | output | IDX_W (3) | Index of the winning BAR |
| pbus_addr | output | 16 | Internal peripheral-bus address |
| conflict | output | 1 | Sticky multiple-match flag |

## Verification
The conflict-clear property assumes that a clearing write never lands in the same cycle as a decode strobe. If the two coincide, the set takes priority. The stimulus therefore clears the flag only between strobes. The properties also assume that io_valid is held low during reset. The bench uses three sweeps over the address range, each with its own set of programmed registers: one with no valid register, one with disjoint blocks, and one where a wide mask overlaps several lower-index blocks. It computes the expected result of each cycle from a model of the register fields.

// File: rtl/iobd_pkg.sv
package iobd_pkg;
   localparam int BAR_W       = 32;
   localparam int HADDR_W     = 16;
   localparam int FRAME_W     = 6;
   localparam int MASK_W      = 8;
   localparam int BYTES_PER   = 4;
   localparam int FRAME_SHIFT = 10;
   localparam int PBUS_W      = FRAME_W + FRAME_SHIFT;

   typedef struct packed {
      logic [HADDR_W-1:0] haddr;
      logic               valid;
      logic               dev;
      logic [FRAME_W-1:0] frame;
      logic [MASK_W-1:0]  mask;
   } bar_t;

   typedef enum logic [1:0] {
      BYTE_MASK = 2'd0,
      BYTE_CTL  = 2'd1,
      BYTE_ALO  = 2'd2,
      BYTE_AHI  = 2'd3
   } bar_byte_e;
endpackage

// File: rtl/iobd_bar_regs.sv
module iobd_bar_regs
   import iobd_pkg::*;
#(
   parameter int NUM_BARS = 8,
   parameter logic [NUM_BARS-1:0][BAR_W-1:0] BAR_RESET = '0,
   parameter logic [NUM_BARS-1:0] MASK_RW = '0,
   parameter int REG_AW = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_wr,
   input  logic [REG_AW-1:0]        reg_addr,
   input  logic [7:0]               reg_wdata,
   output bar_t [NUM_BARS-1:0]      bars
);
   localparam int SLOT_W = REG_AW - 2;

   logic [SLOT_W-1:0] slot;
   bar_byte_e         bsel;

   assign slot = reg_addr[REG_AW-1:2];
   assign bsel = bar_byte_e'(reg_addr[1:0]);

   for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
      localparam bar_t RST = bar_t'(BAR_RESET[i]);
      logic               sel;
      logic [HADDR_W-1:0] haddr_q;
      logic               valid_q;
      logic [MASK_W-1:0]  mask_v;

      assign sel = reg_wr && (slot == SLOT_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            haddr_q <= RST.haddr;
            valid_q <= RST.valid;
         end else if (sel) begin
            case (bsel)
               BYTE_AHI: haddr_q[15:8] <= reg_wdata;
               BYTE_ALO: haddr_q[7:0]  <= reg_wdata;
               BYTE_CTL: valid_q       <= reg_wdata[7];
               default:  ;
            endcase
         end
      end

      if (MASK_RW[i]) begin : g_mask_rw
         logic [MASK_W-1:0] mask_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               mask_q <= RST.mask;
            else if (sel && bsel == BYTE_MASK)
               mask_q <= reg_wdata[MASK_W-1:0];
         end
         assign mask_v = mask_q;
      end else begin : g_mask_ro
         assign mask_v = RST.mask;
      end

      assign bars[i].haddr = haddr_q;
      assign bars[i].valid = valid_q;
      assign bars[i].dev   = RST.dev;
      assign bars[i].frame = RST.frame;
      assign bars[i].mask  = mask_v;
   end
endmodule

// File: rtl/iobd_match.sv
module iobd_match
   import iobd_pkg::*;
#(
   parameter int NUM_BARS = 8
) (
   input  logic [HADDR_W-1:0]                   io_addr,
   input  logic [NUM_BARS-1:0][HADDR_W-1:0]     bases,
   input  logic [NUM_BARS-1:0]                  valids,
   input  logic [NUM_BARS-1:0][MASK_W-1:0]      masks,
   output logic [NUM_BARS-1:0]                  hits
);
   localparam int PAD_W = HADDR_W - MASK_W;

   for (genvar i = 0; i < NUM_BARS; i++) begin : g_cmp
      logic [HADDR_W-1:0] care;
      logic [HADDR_W-1:0] diff;
      assign care    = ~{{PAD_W{1'b0}}, masks[i]};
      assign diff    = (io_addr ^ bases[i]) & care;
      assign hits[i] = valids[i] && (diff == '0);
   end
endmodule

// File: rtl/iobd_select.sv
module iobd_select
   import iobd_pkg::*;
#(
   parameter int NUM_BARS = 8,
   parameter int IDX_W = 3
) (
   input  logic [NUM_BARS-1:0]                 hits,
   input  logic [NUM_BARS-1:0][FRAME_W-1:0]    frames,
   input  logic [NUM_BARS-1:0][MASK_W-1:0]     masks,
   input  logic [MASK_W-1:0]                   offs_addr,
   output logic                                any_hit,
   output logic                                multi_hit,
   output logic [IDX_W-1:0]                    win_idx,
   output logic [PBUS_W-1:0]                   win_pbus
);
   logic [FRAME_W-1:0] frame_sel;
   logic [MASK_W-1:0]  mask_sel;
   logic [MASK_W-1:0]  offset;

   assign any_hit   = |hits;
   assign multi_hit = (hits & (hits - NUM_BARS'(1))) != '0;

   always_comb begin
      win_idx   = '0;
      frame_sel = '0;
      mask_sel  = '0;
      for (int i = NUM_BARS - 1; i >= 0; i--) begin
         if (hits[i]) begin
            win_idx   = IDX_W'(i);
            frame_sel = frames[i];
            mask_sel  = masks[i];
         end
      end
   end

   assign offset   = offs_addr & mask_sel;
   assign win_pbus = (PBUS_W'(frame_sel) << FRAME_SHIFT) + PBUS_W'(offset);
endmodule

// File: rtl/io_bar_decoder.sv
module io_bar_decoder
   import iobd_pkg::*;
#(
   parameter int NUM_BARS = 8,
   parameter logic [NUM_BARS-1:0][BAR_W-1:0] BAR_RESET = {
      32'h0000_0901, 32'h0000_0707, 32'h0000_0507, 32'h0092_0600,
      32'h0066_0407, 32'h0062_0304, 32'h0060_0104, 32'h002E_0C01},
   parameter logic [NUM_BARS-1:0] MASK_RW = 8'b0000_1100,
   parameter int REG_AW = $clog2(BYTES_PER * NUM_BARS + 1),
   parameter int IDX_W = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 io_valid,
   input  logic [HADDR_W-1:0]   io_addr,
   input  logic                 reg_wr,
   input  logic [REG_AW-1:0]    reg_addr,
   input  logic [7:0]           reg_wdata,
   output logic [7:0]           reg_rdata,
   output logic                 claim,
   output logic [IDX_W-1:0]     hit_idx,
   output logic [PBUS_W-1:0]    pbus_addr,
   output logic                 conflict
);
   localparam int SLOT_W = REG_AW - 2;
   localparam logic [REG_AW-1:0] STATUS_ADDR = REG_AW'(BYTES_PER * NUM_BARS);

   if (NUM_BARS < 1) begin : g_bad_count
      $error("io_bar_decoder: NUM_BARS must be at least 1");
   end
   if (REG_AW < $clog2(BYTES_PER * NUM_BARS + 1)) begin : g_bad_aw
      $error("io_bar_decoder: REG_AW too narrow for the register map");
   end
   if ((1 << IDX_W) < NUM_BARS) begin : g_bad_idx
      $error("io_bar_decoder: IDX_W too narrow for NUM_BARS");
   end

   bar_t [NUM_BARS-1:0]              bars;
   logic [NUM_BARS-1:0][HADDR_W-1:0] bases;
   logic [NUM_BARS-1:0]              valids;
   logic [NUM_BARS-1:0][MASK_W-1:0]  masks;
   logic [NUM_BARS-1:0][FRAME_W-1:0] frames;
   logic [NUM_BARS-1:0]              hits;
   logic                             any_hit, multi_hit;
   logic [IDX_W-1:0]                 win_idx;
   logic [PBUS_W-1:0]                win_pbus;
   logic                             clr_conflict;

   iobd_bar_regs #(
      .NUM_BARS  (NUM_BARS),
      .BAR_RESET (BAR_RESET),
      .MASK_RW   (MASK_RW),
      .REG_AW    (REG_AW)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .bars      (bars)
   );

   for (genvar i = 0; i < NUM_BARS; i++) begin : g_unpack
      assign bases[i]  = bars[i].haddr;
      assign valids[i] = bars[i].valid;
      assign masks[i]  = bars[i].mask;
      assign frames[i] = bars[i].frame;
   end

   iobd_match #(.NUM_BARS(NUM_BARS)) i_match (
      .io_addr (io_addr),
      .bases   (bases),
      .valids  (valids),
      .masks   (masks),
      .hits    (hits)
   );

   iobd_select #(.NUM_BARS(NUM_BARS), .IDX_W(IDX_W)) i_select (
      .hits      (hits),
      .frames    (frames),
      .masks     (masks),
      .offs_addr (io_addr[MASK_W-1:0]),
      .any_hit   (any_hit),
      .multi_hit (multi_hit),
      .win_idx   (win_idx),
      .win_pbus  (win_pbus)
   );

   assign clr_conflict = reg_wr && (reg_addr == STATUS_ADDR) && reg_wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         claim     <= 1'b0;
         hit_idx   <= '0;
         pbus_addr <= '0;
      end else if (io_valid && any_hit) begin
         claim     <= 1'b1;
         hit_idx   <= win_idx;
         pbus_addr <= win_pbus;
      end else begin
         claim     <= 1'b0;
         hit_idx   <= '0;
         pbus_addr <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         conflict <= 1'b0;
      else if (io_valid && multi_hit)
         conflict <= 1'b1;
      else if (clr_conflict)
         conflict <= 1'b0;
   end

   always_comb begin
      bar_t sel_bar;
      logic found;
      sel_bar = '0;
      found   = 1'b0;
      for (int i = 0; i < NUM_BARS; i++) begin
         if (reg_addr[REG_AW-1:2] == SLOT_W'(i)) begin
            sel_bar = bars[i];
            found   = 1'b1;
         end
      end
      if (reg_addr == STATUS_ADDR)
         reg_rdata = {7'b0, conflict};
      else if (found)
         case (reg_addr[1:0])
            2'd0:    reg_rdata = sel_bar[7:0];
            2'd1:    reg_rdata = sel_bar[15:8];
            2'd2:    reg_rdata = sel_bar[23:16];
            default: reg_rdata = sel_bar[31:24];
         endcase
      else
         reg_rdata = 8'hFF;
   end
endmodule

// File: rtl/iobd_checker.sv
module iobd_checker
   import iobd_pkg::*;
#(
   parameter int NUM_BARS = 8,
   parameter logic [NUM_BARS-1:0] MASK_RW = '0,
   parameter int REG_AW = 6,
   parameter int IDX_W = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 io_valid,
   input logic                 reg_wr,
   input logic [REG_AW-1:0]    reg_addr,
   input logic [7:0]           reg_wdata,
   input logic                 claim,
   input logic [IDX_W-1:0]     hit_idx,
   input logic [PBUS_W-1:0]    pbus_addr,
   input logic                 conflict,
   input bar_t [NUM_BARS-1:0]  bars
);
   localparam logic [REG_AW-1:0] STATUS_ADDR = REG_AW'(BYTES_PER * NUM_BARS);

   logic clr_wr;
   assign clr_wr = reg_wr && (reg_addr == STATUS_ADDR) && reg_wdata[0];

   assert_claim_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      claim |-> $past(io_valid));

   assert_idle_outputs_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !claim |-> (hit_idx == '0 && pbus_addr == '0));

   assert_offset_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      claim |-> (pbus_addr[FRAME_SHIFT-1:MASK_W] == '0 && int'(hit_idx) < NUM_BARS));

   assert_conflict_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (conflict && !clr_wr) |=> conflict);

   assert_conflict_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !io_valid) |=> !conflict);

   for (genvar i = 0; i < NUM_BARS; i++) begin : g_ro
      assert_id_fields_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $stable({bars[i].dev, bars[i].frame}));
      if (!MASK_RW[i]) begin : g_mask_fixed
         assert_mask_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(bars[i].mask));
      end
   end
endmodule

bind io_bar_decoder iobd_checker #(
   .NUM_BARS (NUM_BARS),
   .MASK_RW  (MASK_RW),
   .REG_AW   (REG_AW),
   .IDX_W    (IDX_W)
) i_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .io_valid  (io_valid),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .claim     (claim),
   .hit_idx   (hit_idx),
   .pbus_addr (pbus_addr),
   .conflict  (conflict),
   .bars      (bars)
);

// File: tb/test_io_bar_decoder.sv
module test_io_bar_decoder;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 8;
   localparam int ST = 4 * NB;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_valid = 1'b0;
   logic [15:0] io_addr = '0;
   logic        reg_wr = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        claim;
   logic [2:0]  hit_idx;
   logic [15:0] pbus_addr;
   logic        conflict;

   int n_checks = 0;
   int n_fail = 0;
   logic [31:0] m_bar [NB];
   bit m_conf;

   always #(CLK_PERIOD/2) clk = ~clk;

   io_bar_decoder i_io_bar_decoder (
      .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_addr(io_addr),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .claim(claim), .hit_idx(hit_idx),
      .pbus_addr(pbus_addr), .conflict(conflict));

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input int a);
      if (a == ST) return {7'b0, m_conf};
      if (a < ST) return m_bar[a/4][8*(a%4) +: 8];
      return 8'hFF;
   endfunction

   task automatic rd_chk(input int a, input string tag);
      @(negedge clk);
      reg_addr = 6'(a);
      #1;
      chk(reg_rdata == exp_rd(a), tag, $sformatf("read @%0d", a),
          32'(reg_rdata), 32'(exp_rd(a)));
   endtask

   task automatic rd_all(input string tag);
      for (int a = 0; a < 64; a++) rd_chk(a, tag);
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      if (a < ST) begin
         int i = a / 4;
         case (a % 4)
            3: m_bar[i][31:24] = d;
            2: m_bar[i][23:16] = d;
            1: m_bar[i][15] = d[7];
            default: if (i == 2 || i == 3) m_bar[i][7:0] = d;
         endcase
      end else if (a == ST && d[0]) m_conf = 1'b0;
   endtask

   task automatic dec(input logic [15:0] a, input string tag);
      bit e_cl = 0; int e_idx = 0; logic [15:0] e_pb = '0; int nh = 0;
      @(negedge clk);
      io_valid = 1'b1; io_addr = a;
      @(negedge clk);
      io_valid = 1'b0;
      for (int i = 0; i < NB; i++) begin
         logic [15:0] mk = {8'h00, m_bar[i][7:0]};
         if (m_bar[i][15] && (((a ^ m_bar[i][31:16]) & ~mk) == 16'h0)) begin
            nh++;
            if (!e_cl) begin
               e_cl = 1; e_idx = i;
               e_pb = 16'(m_bar[i][13:8]) * 16'h400 + 16'(a[7:0] & m_bar[i][7:0]);
            end
         end
      end
      if (nh > 1) m_conf = 1'b1;
      chk({claim, hit_idx, pbus_addr, conflict} == {e_cl, 3'(e_idx), e_pb, m_conf},
          tag, $sformatf("decode %h {claim,idx,pbus,conf}", a),
          {11'b0, claim, hit_idx, pbus_addr, conflict},
          {11'b0, e_cl, 3'(e_idx), e_pb, m_conf});
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL R9 watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      m_bar[0] = 32'h002E_0C01; m_bar[1] = 32'h0060_0104;
      m_bar[2] = 32'h0062_0304; m_bar[3] = 32'h0066_0407;
      m_bar[4] = 32'h0092_0600; m_bar[5] = 32'h0000_0507;
      m_bar[6] = 32'h0000_0707; m_bar[7] = 32'h0000_0901;
      m_conf = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 and R10: reset image and the unmapped space
      chk(claim == 1'b0 && conflict == 1'b0, "R1", "claim/conflict after reset",
          {30'b0, claim, conflict}, 32'h0);
      rd_all("R1");

      // R2: every BAR is invalid after reset, nothing may be claimed
      for (int a = 0; a < 256; a++) dec(16'(a), "R2");

      // R7 R8: write-protection sweep over every byte of every BAR
      for (int i = 0; i < NB; i++)
         for (int b = 0; b < 4; b++) wr(4*i + b, 8'hA5 ^ 8'(4*i + b));
      rd_all("R7");

      // R10: writes above the status byte change nothing
      wr(ST + 1, 8'hFF); wr(63, 8'h00);
      rd_all("R10");

      // R3 R4: disjoint blocks, BAR7 left invalid (R2)
      wr(3, 8'h00); wr(2, 8'h2E); wr(1, 8'hFF);
      wr(7, 8'h00); wr(6, 8'h60); wr(5, 8'h80);
      wr(11, 8'h00); wr(10, 8'h62); wr(8, 8'h00); wr(9, 8'h80);
      wr(15, 8'h00); wr(14, 8'h66); wr(12, 8'h00); wr(13, 8'h80);
      wr(19, 8'h00); wr(18, 8'h92); wr(17, 8'h80);
      wr(23, 8'h02); wr(22, 8'h00); wr(21, 8'h80);
      wr(27, 8'h03); wr(26, 8'hF8); wr(25, 8'h80);
      wr(31, 8'h03); wr(30, 8'h60); wr(29, 8'h00);
      rd_all("R8");
      for (int a = 0; a < 1024; a++) dec(16'(a), "R3");
      dec(16'hF02E, "R3");
      dec(16'h102E, "R3");

      // R9: address on the bus with no strobe is not claimed
      @(negedge clk); io_addr = 16'h002E; io_valid = 1'b0;
      @(negedge clk);
      chk(claim == 1'b0, "R9", "claim without strobe", 32'(claim), 32'h0);

      // R5: BAR3 widened over 00h..FFh overlaps lower BARs and BAR4
      wr(15, 8'h00); wr(14, 8'h00); wr(12, 8'hFF);
      for (int a = 0; a < 512; a++) dec(16'(a), "R5");

      // R6: clearing rules for the sticky flag
      rd_chk(ST, "R6");
      wr(ST, 8'hFE);
      rd_chk(ST, "R6");
      chk(conflict == 1'b1, "R6", "write 0 keeps flag", 32'(conflict), 32'h1);
      wr(ST, 8'h01);
      #1 chk(conflict == 1'b0, "R6", "write 1 clears flag", 32'(conflict), 32'h0);
      rd_chk(ST, "R6");
      dec(16'h0033, "R6");
      dec(16'h0092, "R5");
      dec(16'h002F, "R4");

      finish_run();
   end
endmodule